// File: doc/BRIEF.md
# Reference Clock Switchover Sequencer

This block picks which of two reference clocks feeds a clock-synthesis unit, and it sequences every change of that choice. When a switch request is accepted, the block first puts the unit into reset. It holds the reset for a programmed number of cycles and only then moves the select line. It keeps the reset for the same number of cycles again, and then releases it through a synchroniser clocked by the running clock. Finally it waits for the unit's lock indication to come back. The sequence ends in one of two ways: a single-cycle completion pulse, or a timeout flag if lock stays away too long.

The block can also switch the unit off entirely. It accepts a power-down request only when no switchover is running. Power-down holds both the power-off line and the reset. When the request is withdrawn, the unit comes back through the same path used by a switch: a reset hold, a synchronised release and a lock wait.

A switch request always runs the full sequence, even when the requested input is already selected. A request that arrives while a sequence is running is dropped.

Top module: `refclk_switch_seq`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it: `unit_sel` is 1, and `unit_rst`, `unit_pwrdn`, `busy`, `done` and `timeout_err` are 0.
- R2: When the block is idle (`busy` and `unit_pwrdn` both low), a high `sw_req` is accepted at the clock edge, and `unit_rst` and `busy` are high in the following cycle. `unit_sel` takes the value of `sw_target` after exactly HOLD_CYC cycles with `unit_rst` high. `unit_sel` = 1 selects reference input 1 and `unit_sel` = 0 selects reference input 2.
- R3: `unit_sel` changes only in a cycle where `unit_rst` is high both before and after the change.
- R4: `unit_rst` is entered combinationally but released only through SYNC_STAGES clock stages. In a switch it stays high for exactly 2*HOLD_CYC + SYNC_STAGES cycles.
- R5: `busy` is high from the cycle after an accepted request until the cycle in which the sequence ends.
- R6: Once reset has been released, the first cycle in which the synchronised lock is high produces a `done` pulse one cycle long. `busy` falls at the same time as `done` rises.
- R7: A `sw_req` that arrives while `busy` is high is ignored. The select line ends at the target of the accepted request, and exactly one `done` pulse follows.
- R8: If lock has not returned within LOCK_TMO cycles (default 1024) of entering the lock wait, `timeout_err` goes high, `busy` falls and no `done` is given. In that case `busy` is high for 2*HOLD_CYC + LOCK_TMO cycles. `timeout_err` is cleared by the next accepted switch request.
- R9: A high `pd_req` while idle raises both `unit_pwrdn` and `unit_rst` in the next cycle, with `busy` low. A `pd_req` during a switch never raises `unit_pwrdn`.
- R10: Once `pd_req` falls, `unit_pwrdn` drops on the next edge and `unit_rst` stays high for HOLD_CYC + SYNC_STAGES cycles. `unit_sel` does not change, and the sequence ends with a `done` pulse once lock returns.
- R11: `sw_req` has no effect during power-down. When `sw_req` and `pd_req` are both high while idle, the switch is taken and power-down is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Running clock for the sequencer |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_req | input | 1 | Request to run a switchover |
| sw_target | input | 1 | Requested selection (1 = input 1, 0 = input 2), sampled with `sw_req` |
| pd_req | input | 1 | Level request to power the unit down |
| lock_in | input | 1 | Lock indication from the clock unit (asynchronous) |
| unit_sel | output | 1 | Reference select to the unit, 1 = input 1 |
| unit_rst | output | 1 | Reset to the clock unit |
| unit_pwrdn | output | 1 | Power-down to the clock unit |
| busy | output | 1 | A switchover or power-up sequence is running |
| done | output | 1 | One-cycle pulse when lock is regained |
| timeout_err | output | 1 | Lock did not return in time |

## Verification
The hardest case to reach from the ports is a request that lands while a sequence is already running, particularly when it is mixed with a power-down request. A quiet bench never places requests in that window. The stimulus therefore pulses `sw_req` with the opposite target together with `pd_req` a few cycles into a sequence, and it also pulses `sw_req` in the middle of a power-down. The lock timeout needs the unit model to withhold lock entirely for more than a thousand cycles. Random trials choose this outcome at a low rate, and one directed case always forces it.

// File: rtl/refsw_pkg.sv
// Package: shared state encoding for the reference switchover sequencer.
// Assumes: nothing beyond the importing modules.
package refsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_HOLD_PRE  = 3'd1,
        ST_HOLD_POST = 3'd2,
        ST_WAIT_LOCK = 3'd3,
        ST_PWRDN     = 3'd4
    } seq_state_t;

endpackage

// File: rtl/refsw_sync.sv
// Module: multi-stage flop synchroniser for a single asynchronous level.
// Assumes: the input is a slow level (lock), so no pulse stretching is needed.
module refsw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d};
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/refsw_rst_gen.sv
// Module: reset driver for the clock unit. Assertion follows hold_req at once,
// release is delayed through STAGES flops of the running clock.
// Assumes: hold_req comes from a register in the clk domain.
module refsw_rst_gen #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_req,
    output logic unit_rst
);
    logic [STAGES-1:0] tail_q;

    // Fill the release chain while the hold is requested, drain it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_q <= '0;
        end else begin
            tail_q[0] <= hold_req;
            for (int i = 1; i < STAGES; i++) begin
                tail_q[i] <= tail_q[i-1];
            end
        end
    end

    assign unit_rst = hold_req | tail_q[STAGES-1];
endmodule

// File: rtl/refsw_cnt.sv
// Module: saturating phase counter, cleared on every state change.
// Assumes: WIDTH covers the largest compare value of the sequencer.
module refsw_cnt #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] TOP = '1;

    // Count cycles spent in the current phase, stopping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            value <= '0;
        end else if (value != TOP) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/refclk_switch_seq.sv
// Module: top of the reference clock switchover sequencer. The FSM runs
// reset hold, select change, reset hold, synchronised release and lock wait,
// and it gates power-down to the idle state.
// Assumes: the clock unit drops lock while it is held in reset, and clk keeps
// running while the unit is reset or powered down.
module refclk_switch_seq
    import refsw_pkg::*;
#(
    parameter int HOLD_CYC    = 8,
    parameter int LOCK_TMO    = 1024,
    parameter int SYNC_STAGES = 2,
    parameter bit SEL_INIT    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_req,
    input  logic sw_target,
    input  logic pd_req,
    input  logic lock_in,
    output logic unit_sel,
    output logic unit_rst,
    output logic unit_pwrdn,
    output logic busy,
    output logic done,
    output logic timeout_err
);
    localparam int CNT_MAX = (HOLD_CYC > LOCK_TMO) ? HOLD_CYC : LOCK_TMO;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST  = CNT_W'(LOCK_TMO - 1);

    seq_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             hold_end, tmo_end;
    logic             lock_s, lock_ok;
    logic             hold_req;
    logic             accept_sw;
    logic             target_q, sel_q, done_q, err_q;

    refsw_sync #(.STAGES(SYNC_STAGES)) lock_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lock_in),
        .q     (lock_s)
    );

    refsw_cnt #(.WIDTH(CNT_W)) phase_cnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .value (cnt)
    );

    refsw_rst_gen #(.STAGES(SYNC_STAGES)) rst_gen_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_req (hold_req),
        .unit_rst (unit_rst)
    );

    assign hold_end  = (cnt == HOLD_LAST);
    assign tmo_end   = (cnt == TMO_LAST);
    assign lock_ok   = lock_s & ~unit_rst;
    assign accept_sw = (state_q == ST_IDLE) && sw_req;
    assign cnt_clr   = (state_d != state_q);
    assign hold_req  = (state_q == ST_HOLD_PRE) || (state_q == ST_HOLD_POST)
                    || (state_q == ST_PWRDN);

    // Next-state selection for the switchover and power-down sequences.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sw_req)      state_d = ST_HOLD_PRE;
                else if (pd_req) state_d = ST_PWRDN;
            end
            ST_HOLD_PRE:  if (hold_end) state_d = ST_HOLD_POST;
            ST_HOLD_POST: if (hold_end) state_d = ST_WAIT_LOCK;
            ST_WAIT_LOCK: if (lock_ok || tmo_end) state_d = ST_IDLE;
            ST_PWRDN:     if (!pd_req) state_d = ST_HOLD_POST;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the requested target and apply it at the end of the first hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= SEL_INIT;
            sel_q    <= SEL_INIT;
        end else begin
            if (accept_sw) target_q <= sw_target;
            if (state_q == ST_HOLD_PRE && hold_end) sel_q <= target_q;
        end
    end

    // Completion pulse and sticky timeout flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= (state_q == ST_WAIT_LOCK) && lock_ok;
            if (accept_sw) begin
                err_q <= 1'b0;
            end else if (state_q == ST_WAIT_LOCK && !lock_ok && tmo_end) begin
                err_q <= 1'b1;
            end
        end
    end

    assign unit_sel    = sel_q;
    assign unit_pwrdn  = (state_q == ST_PWRDN);
    assign busy        = (state_q == ST_HOLD_PRE) || (state_q == ST_HOLD_POST)
                      || (state_q == ST_WAIT_LOCK);
    assign done        = done_q;
    assign timeout_err = err_q;
endmodule

// File: rtl/refclk_switch_seq_chk.sv
// Module: property checker for the switchover sequencer, bound to the top.
// Assumes: connected by name to the top module's ports.
module refclk_switch_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_req,
    input logic sw_target,
    input logic pd_req,
    input logic lock_in,
    input logic unit_sel,
    input logic unit_rst,
    input logic unit_pwrdn,
    input logic busy,
    input logic done,
    input logic timeout_err
);
    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !unit_pwrdn && sw_req) |=> (busy && unit_rst));

    assert_sel_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel != $past(unit_sel)) |-> (unit_rst && $past(unit_rst)));

    assert_busy_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> !done);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !unit_rst));

    assert_err_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!busy && !done));

    assert_pwrdn_from_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unit_pwrdn) |-> $past(!busy));

    assert_pwrdn_in_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unit_pwrdn |-> (unit_rst && !busy));

    assert_pd_sel_still_R11: assert property (@(posedge clk) disable iff (!rst_n)
        unit_pwrdn |=> $stable(unit_sel));
endmodule

bind refclk_switch_seq refclk_switch_seq_chk chk_i (.*);

// File: tb/refclk_switch_seq_tb_top.sv
// Bench: random and directed switchovers and power-down cycles against a
// behavioural clock-unit model. Expected values come from the requirements.
module refclk_switch_seq_tb_top;
    localparam int HOLD = 8;
    localparam int TMO  = 1024;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst_n, sw_req, sw_target, pd_req, lock;
    logic sel, urst, pwrdn, busy, done, err;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    bit  exp_sel = 1'b1;
    bit  exp_err = 1'b0;
    int  lock_dly = 5;
    bit  lock_never = 1'b0;
    int  stub_cnt;

    always #4 clk = ~clk;

    refclk_switch_seq dut_i (
        .clk (clk), .rst_n (rst_n), .sw_req (sw_req), .sw_target (sw_target),
        .pd_req (pd_req), .lock_in (lock), .unit_sel (sel), .unit_rst (urst),
        .unit_pwrdn (pwrdn), .busy (busy), .done (done), .timeout_err (err)
    );

    // Unit model: loses lock in reset or power-down, relocks after lock_dly cycles.
    always @(posedge clk) begin
        if (urst || pwrdn || !rst_n) begin
            stub_cnt <= 0;
            lock     <= 1'b0;
        end else if (!lock_never) begin
            if (stub_cnt >= lock_dly) lock <= 1'b1;
            else                      stub_cnt <= stub_cnt + 1;
        end
    end

    function automatic int switch_rst_len();
        return 2 * HOLD + SYNC;
    endfunction

    function automatic int pd_exit_rst_len();
        return HOLD + SYNC;
    endfunction

    function automatic int timeout_busy_len();
        return 2 * HOLD + TMO;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_switch(input bit tgt, input int dly, input bit never,
                             input bit noisy, input bit with_pd);
        bit old;
        bit prev_sel;
        bit prev_rst;
        int n_busy, n_rst, n_pre, n_done, n_pd, i;
        old = exp_sel;
        lock_dly = dly;
        lock_never = never;
        @(negedge clk);
        sw_req = 1'b1; sw_target = tgt; pd_req = with_pd;
        @(negedge clk);
        sw_req = 1'b0; pd_req = 1'b0;
        check(urst == 1'b1, "R2 reset raised after accept", urst, 1);
        check(busy == 1'b1, "R5 busy after accept", busy, 1);
        check(err == 1'b0, "R8 error cleared on accept", err, 0);
        n_busy = 0; n_rst = 0; n_pre = 0; n_done = 0; n_pd = 0; i = 0;
        prev_sel = sel; prev_rst = urst;
        while (1) begin
            if (busy) n_busy++;
            if (urst) n_rst++;
            if (urst && sel == old) n_pre++;
            if (done) n_done++;
            if (pwrdn) n_pd++;
            if (sel != prev_sel)
                check(urst && prev_rst, "R3 select moved outside reset", urst, 1);
            prev_sel = sel; prev_rst = urst;
            if (!busy) break;
            if (noisy && i == 3) begin
                sw_req = 1'b1; sw_target = ~tgt; pd_req = 1'b1;
            end else if (noisy && i == 5) begin
                sw_req = 1'b0; pd_req = 1'b0;
            end
            i++;
            @(negedge clk);
        end
        check(n_rst == switch_rst_len(), "R4 reset length", n_rst, switch_rst_len());
        if (tgt != old)
            check(n_pre == HOLD, "R2 hold before select change", n_pre, HOLD);
        check(n_pd == 0, with_pd ? "R11 switch wins over power-down" : "R9 no power-down while busy",
              n_pd, 0);
        check(sel == tgt, noisy ? "R7 late request ignored" : "R2 select value", sel, tgt);
        if (never) begin
            check(err == 1'b1, "R8 timeout flag", err, 1);
            check(n_done == 0, "R8 no done on timeout", n_done, 0);
            check(n_busy == timeout_busy_len(), "R8 busy length on timeout",
                  n_busy, timeout_busy_len());
        end else begin
            check(n_done == 1, noisy ? "R7 single done" : "R6 done seen", n_done, 1);
            check(err == 1'b0, "R8 no error on lock", err, 0);
            check(n_busy >= switch_rst_len(), "R5 busy spans sequence", n_busy, switch_rst_len());
        end
        @(negedge clk);
        check(done == 1'b0, "R6 done lasts one cycle", done, 0);
        check(pwrdn == 1'b0, "R9 no late power-down", pwrdn, 0);
        exp_sel = tgt;
        exp_err = never;
    endtask

    task automatic do_pd(input int hold, input int dly, input bit poke);
        int n_rst, n_done;
        lock_never = 1'b0;
        lock_dly = dly;
        @(negedge clk);
        pd_req = 1'b1;
        @(negedge clk);
        check(pwrdn == 1'b1, "R9 power-down entered", pwrdn, 1);
        check(urst == 1'b1, "R9 reset held in power-down", urst, 1);
        check(busy == 1'b0, "R9 not busy in power-down", busy, 0);
        for (int k = 0; k < hold; k++) begin
            if (poke && k == 0) begin sw_req = 1'b1; sw_target = ~exp_sel; end
            else sw_req = 1'b0;
            @(negedge clk);
        end
        sw_req = 1'b0;
        check(pwrdn == 1'b1, "R11 power-down kept", pwrdn, 1);
        check(sel == exp_sel, "R11 request ignored in power-down", sel, exp_sel);
        pd_req = 1'b0;
        @(negedge clk);
        check(pwrdn == 1'b0, "R10 power-down dropped", pwrdn, 0);
        n_rst = 0; n_done = 0;
        while (1) begin
            if (urst) n_rst++;
            if (done) n_done++;
            if (!busy) break;
            @(negedge clk);
        end
        check(n_rst == pd_exit_rst_len(), "R10 reset length on exit", n_rst, pd_exit_rst_len());
        check(n_done == 1, "R10 done after exit", n_done, 1);
        check(sel == exp_sel, "R10 select unchanged", sel, exp_sel);
        check(err == exp_err, "R10 error flag untouched", err, exp_err);
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Main stimulus: directed corners, then seeded random trials.
    initial begin
        int r;
        void'($urandom(32'd4711));
        rst_n = 1'b0; sw_req = 1'b0; sw_target = 1'b0; pd_req = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(sel == 1'b1, "R1 select at reset", sel, 1);
        check(urst == 1'b0, "R1 unit reset at reset", urst, 0);
        check(pwrdn == 1'b0, "R1 power-down at reset", pwrdn, 0);
        check(busy == 1'b0 && done == 1'b0, "R1 busy/done at reset", busy, 0);
        check(err == 1'b0, "R1 error at reset", err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sel == 1'b1 && busy == 1'b0, "R1 state after release", sel, 1);
        repeat (20) @(negedge clk);

        do_switch(1'b0, 10, 1'b0, 1'b0, 1'b0);
        do_switch(1'b0, 3, 1'b0, 1'b1, 1'b0);
        do_switch(1'b1, 7, 1'b0, 1'b0, 1'b1);
        do_switch(1'b0, 0, 1'b1, 1'b0, 1'b0);
        do_switch(1'b1, 1, 1'b0, 1'b0, 1'b0);
        do_pd(5, 4, 1'b1);

        for (int t = 0; t < 25; t++) begin
            r = int'($urandom % 8);
            if (r < 5) begin
                do_switch(1'($urandom % 2), 1 + int'($urandom % 60),
                          ($urandom % 10) == 0, r[0], r == 4);
            end else begin
                do_pd(2 + int'($urandom % 20), 1 + int'($urandom % 40), r[0]);
            end
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule